// File: doc/BRIEF.md
# Compressed Audio Bitstream Detector

This block sits after a serial digital audio receiver that has already recovered one 16-bit audio word per subframe. It watches that word stream for the marker of a compressed burst payload and for the sync word of a 14-bit packed compressed stream. A downstream audio path uses the resulting flags to mute or reroute data that must not be played as PCM. When a burst marker is found, the block also captures the two header words that follow it, the burst information word and the length word, so the host path can read them.

Each flag is sticky. Every fresh sync re-arms it, and a frame counter clears it once 4096 frames pass with no new sync. A combined flag is high whenever either stream kind is present.

Control is split into three state machines. The burst matcher has the states `PA_IDLE`, `PA_Z1`, `PA_Z2`, `PA_Z3`, `PA_Z4`, `PA_SYNC_A`, `PA_TAKE_INFO` and `PA_TAKE_LEN`. It moves one state forward for each zero word. It stays in `PA_Z4` while more zeros arrive. It goes from `PA_Z4` to `PA_SYNC_A` on 0xF872, and from `PA_SYNC_A` to `PA_TAKE_INFO` on 0x4E1F (the detection). It then passes to `PA_TAKE_LEN` and back to `PA_IDLE` as the two header words go by. On any other word it falls back to `PA_Z1` if that word is zero and to `PA_IDLE` otherwise. The packed-sync matcher has the states `PK_IDLE`, `PK_HI` and `PK_MID`. It goes to `PK_HI` on 0x1FFF and to `PK_MID` on 0xE800, and it detects when the next word has upper twelve bits 0x07F. On a mismatch it returns to `PK_HI` if the word is 0x1FFF and to `PK_IDLE` otherwise. Each hold timer has the states `HT_OFF` and `HT_HOLD`. It enters `HT_HOLD` on a detection, counts frame strobes, and returns to `HT_OFF` on the 4096th strobe without a detection.

Top module: `cbs_detect`

## Requirements
- R1: After reset, `burst_flag_o`, `pk_flag_o` and `any_flag_o` are 0, and `burst_info_o` and `burst_len_o` are 0x0000.
- R2: Six consecutive valid words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F set `burst_flag_o` to 1. The flag is visible on the clock edge after the edge that accepts the last word.
- R3: More than four leading zero words still match. A word that breaks the sequence restarts matching, and that word counts as the first matched word if it is 0x0000.
- R4: The first valid word after a detected burst sequence is loaded into `burst_info_o` and the second into `burst_len_o`. Both hold their values until the next detection. These two words never take part in matching.
- R5: `burst_flag_o` returns to 0 on the 4096th `frame_i` strobe accepted after the latest burst detection. A new detection restarts that count.
- R6: Valid words 0x1FFF and then 0xE800, followed by a valid word whose bits [15:4] are 0x07F, set `pk_flag_o` to 1 on the edge after the third word.
- R7: The 16-bit form of the packed sync, 0x7FFE followed by 0x8001, does not set `pk_flag_o`.
- R8: `pk_flag_o` clears on the 4096th frame strobe after its latest detection. It has its own counter, independent of `burst_flag_o`.
- R9: `any_flag_o` equals `burst_flag_o` OR `pk_flag_o` in every cycle.
- R10: Cycles with `word_vld_i` low have no effect on matching or on the captured header words.
- R11: A detection in the same cycle as a frame strobe re-arms the flag, and that strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 16 | Decoded audio word of one subframe |
| word_vld_i | input | 1 | `word_i` holds a new word this cycle |
| frame_i | input | 1 | One-cycle strobe at each frame start |
| burst_flag_o | output | 1 | Burst payload present |
| pk_flag_o | output | 1 | 14-bit packed compressed stream present |
| any_flag_o | output | 1 | Either stream kind present |
| burst_info_o | output | 16 | Captured burst information word |
| burst_len_o | output | 16 | Captured burst length word |

## Verification
The checker assumes that `frame_i` and `word_vld_i` are single-cycle strobes sampled on the rising edge. It also assumes that `word_i` matters only in cycles with `word_vld_i` high, so a header capture or a flag rise can always be traced to the valid word accepted one edge earlier. The bench drives every input at the falling edge and holds it for exactly one rising edge. It interleaves idle cycles in which `word_i` carries garbage but `word_vld_i` is low, so that each property is tested against data that must be ignored.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] BURST_SYNC_A = 16'hF872;
    localparam logic [WORD_W-1:0] BURST_SYNC_B = 16'h4E1F;
    localparam logic [WORD_W-1:0] PK_SYNC_HI   = 16'h1FFF;
    localparam logic [WORD_W-1:0] PK_SYNC_MID  = 16'hE800;
    localparam logic [11:0]       PK_SYNC_LO12 = 12'h07F;

    typedef enum logic [2:0] {
        PA_IDLE,
        PA_Z1,
        PA_Z2,
        PA_Z3,
        PA_Z4,
        PA_SYNC_A,
        PA_TAKE_INFO,
        PA_TAKE_LEN
    } pa_state_t;

    typedef enum logic [1:0] {
        PK_IDLE,
        PK_HI,
        PK_MID
    } pk_state_t;

    typedef enum logic {
        HT_OFF,
        HT_HOLD
    } ht_state_t;
endpackage

// File: rtl/cbs_burst_sync.sv
module cbs_burst_sync
    import cbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              vld_i,
    output logic              hit_o,
    output logic [WORD_W-1:0] info_o,
    output logic [WORD_W-1:0] len_o
);
    pa_state_t state_q, state_d;
    logic      is_zero;

    assign is_zero = (word_i == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PA_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and detection pulse
    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        if (vld_i) begin
            unique case (state_q)
                PA_IDLE:      state_d = is_zero ? PA_Z1 : PA_IDLE;
                PA_Z1:        state_d = is_zero ? PA_Z2 : PA_IDLE;
                PA_Z2:        state_d = is_zero ? PA_Z3 : PA_IDLE;
                PA_Z3:        state_d = is_zero ? PA_Z4 : PA_IDLE;
                PA_Z4: begin
                    if (is_zero) begin
                        state_d = PA_Z4;
                    end else if (word_i == BURST_SYNC_A) begin
                        state_d = PA_SYNC_A;
                    end else begin
                        state_d = PA_IDLE;
                    end
                end
                PA_SYNC_A: begin
                    if (word_i == BURST_SYNC_B) begin
                        state_d = PA_TAKE_INFO;
                        hit_o   = 1'b1;
                    end else begin
                        state_d = is_zero ? PA_Z1 : PA_IDLE;
                    end
                end
                PA_TAKE_INFO: state_d = PA_TAKE_LEN;
                PA_TAKE_LEN:  state_d = PA_IDLE;
                default:      state_d = PA_IDLE;
            endcase
        end
    end

    // header word capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_o <= '0;
            len_o  <= '0;
        end else if (vld_i) begin
            if (state_q == PA_TAKE_INFO) begin
                info_o <= word_i;
            end
            if (state_q == PA_TAKE_LEN) begin
                len_o <= word_i;
            end
        end
    end
endmodule

// File: rtl/cbs_pk_sync.sv
module cbs_pk_sync
    import cbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              vld_i,
    output logic              hit_o
);
    pk_state_t state_q, state_d;
    logic      is_hi;

    assign is_hi = (word_i == PK_SYNC_HI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        if (vld_i) begin
            unique case (state_q)
                PK_IDLE: state_d = is_hi ? PK_HI : PK_IDLE;
                PK_HI: begin
                    if (word_i == PK_SYNC_MID) begin
                        state_d = PK_MID;
                    end else begin
                        state_d = is_hi ? PK_HI : PK_IDLE;
                    end
                end
                PK_MID: begin
                    if (word_i[WORD_W-1:4] == PK_SYNC_LO12) begin
                        hit_o   = 1'b1;
                        state_d = PK_IDLE;
                    end else begin
                        state_d = is_hi ? PK_HI : PK_IDLE;
                    end
                end
                default: state_d = PK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cbs_hold_timer.sv
module cbs_hold_timer
    import cbs_pkg::*;
#(
    parameter int HOLD_FRAMES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic frame_i,
    output logic flag_o
);
    localparam int CNT_W = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_FRAMES - 1);

    ht_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HT_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HT_OFF: begin
                if (hit_i) begin
                    state_d = HT_HOLD;
                    cnt_d   = '0;
                end
            end
            HT_HOLD: begin
                if (hit_i) begin
                    cnt_d = '0;
                end else if (frame_i) begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = HT_OFF;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = HT_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    assign flag_o = (state_q == HT_HOLD);
endmodule

// File: rtl/cbs_detect.sv
module cbs_detect
    import cbs_pkg::*;
#(
    parameter int HOLD_FRAMES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] word_i,
    input  logic        word_vld_i,
    input  logic        frame_i,
    output logic        burst_flag_o,
    output logic        pk_flag_o,
    output logic        any_flag_o,
    output logic [15:0] burst_info_o,
    output logic [15:0] burst_len_o
);
    localparam int N_KIND = 2;

    logic [N_KIND-1:0] hit;
    logic [N_KIND-1:0] flag;

    cbs_burst_sync u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (word_i),
        .vld_i  (word_vld_i),
        .hit_o  (hit[0]),
        .info_o (burst_info_o),
        .len_o  (burst_len_o)
    );

    cbs_pk_sync u_pk (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (word_i),
        .vld_i  (word_vld_i),
        .hit_o  (hit[1])
    );

    for (genvar g = 0; g < N_KIND; g++) begin : g_hold
        cbs_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit[g]),
            .frame_i (frame_i),
            .flag_o  (flag[g])
        );
    end

    assign burst_flag_o = flag[0];
    assign pk_flag_o    = flag[1];
    assign any_flag_o   = |flag;
endmodule

// File: rtl/cbs_detect_chk.sv
module cbs_detect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] word_i,
    input logic        word_vld_i,
    input logic        frame_i,
    input logic        burst_flag_o,
    input logic        pk_flag_o,
    input logic        any_flag_o,
    input logic [15:0] burst_info_o,
    input logic [15:0] burst_len_o
);
    assert_burst_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_flag_o) |-> ($past(word_vld_i) && $past(word_i) == 16'h4E1F));

    assert_pk_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pk_flag_o) |-> ($past(word_vld_i) && $past(word_i[15:4]) == 12'h07F));

    assert_burst_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(burst_flag_o) |-> $past(frame_i));

    assert_pk_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pk_flag_o) |-> $past(frame_i));

    assert_hdr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_i |=> ($stable(burst_info_o) && $stable(burst_len_o)));

    assert_any_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_flag_o) |-> ($rose(burst_flag_o) || $rose(pk_flag_o)));
endmodule

bind cbs_detect cbs_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_i       (word_i),
    .word_vld_i   (word_vld_i),
    .frame_i      (frame_i),
    .burst_flag_o (burst_flag_o),
    .pk_flag_o    (pk_flag_o),
    .any_flag_o   (any_flag_o),
    .burst_info_o (burst_info_o),
    .burst_len_o  (burst_len_o)
);

// File: tb/test_cbs_detect.sv
`timescale 1ns/1ps
module test_cbs_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word_i = '0;
    logic        word_vld_i = 1'b0;
    logic        frame_i = 1'b0;
    logic        burst_flag_o, pk_flag_o, any_flag_o;
    logic [15:0] burst_info_o, burst_len_o;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    cbs_detect i_cbs_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_i       (word_i),
        .word_vld_i   (word_vld_i),
        .frame_i      (frame_i),
        .burst_flag_o (burst_flag_o),
        .pk_flag_o    (pk_flag_o),
        .any_flag_o   (any_flag_o),
        .burst_info_o (burst_info_o),
        .burst_len_o  (burst_len_o)
    );

    // behavioural reference: word histories, skip counter, frame counters
    logic [15:0] hb[$];
    logic [15:0] hk[$];
    int          m_skip = 0;
    int          m_bcnt = 0;
    int          m_kcnt = 0;
    bit          m_bflag = 0;
    bit          m_kflag = 0;
    logic [15:0] m_info = '0;
    logic [15:0] m_len = '0;

    always @(posedge clk) begin
        bit          bdet, kdet;
        logic [15:0] last;
        bdet = 0;
        kdet = 0;
        if (!rst_n) begin
            hb.delete();
            hk.delete();
            m_skip = 0; m_bcnt = 0; m_kcnt = 0;
            m_bflag = 0; m_kflag = 0;
            m_info = '0; m_len = '0;
        end else begin
            if (word_vld_i) begin
                if (m_skip == 2) begin
                    m_info = word_i; m_skip = 1;
                end else if (m_skip == 1) begin
                    m_len = word_i; m_skip = 0;
                end else begin
                    hb.push_back(word_i);
                    if (hb.size() > 6) void'(hb.pop_front());
                    if (hb.size() == 6 && hb[0] == 0 && hb[1] == 0 && hb[2] == 0 &&
                        hb[3] == 0 && hb[4] == 16'hF872 && hb[5] == 16'h4E1F) begin
                        bdet = 1; m_skip = 2; hb.delete();
                    end
                end
                hk.push_back(word_i);
                if (hk.size() > 3) void'(hk.pop_front());
                if (hk.size() == 3) begin
                    last = hk[2];
                    if (hk[0] == 16'h1FFF && hk[1] == 16'hE800 && last[15:4] == 12'h07F)
                        kdet = 1;
                end
            end
            if (bdet) begin
                m_bflag = 1; m_bcnt = 0;
            end else if (frame_i && m_bflag) begin
                if (m_bcnt == 4095) begin m_bflag = 0; m_bcnt = 0; end
                else m_bcnt++;
            end
            if (kdet) begin
                m_kflag = 1; m_kcnt = 0;
            end else if (frame_i && m_kflag) begin
                if (m_kcnt == 4095) begin m_kflag = 0; m_kcnt = 0; end
                else m_kcnt++;
            end
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk({phase, " burst flag R2/R5"}, {15'd0, burst_flag_o}, {15'd0, m_bflag});
        chk({phase, " pk flag R6/R8"}, {15'd0, pk_flag_o}, {15'd0, m_kflag});
        chk({phase, " any flag R9"}, {15'd0, any_flag_o}, {15'd0, m_bflag | m_kflag});
        chk({phase, " info R4"}, burst_info_o, m_info);
        chk({phase, " len R4"}, burst_len_o, m_len);
    endtask

    // drive one cycle, then compare after the consuming edge
    task automatic step(bit v, logic [15:0] w, bit f);
        word_vld_i = v;
        word_i     = w;
        frame_i    = f;
        @(negedge clk);
        compare_model();
    endtask

    task automatic idle_frames(int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 16'h2222, 1'b1);
            step(1'b1, 16'h3333, 1'b0);
        end
    endtask

    task automatic burst_seq(logic [15:0] info, logic [15:0] len, bit f_last);
        for (int i = 0; i < 4; i++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'hF872, 1'b0);
        step(1'b1, 16'h4E1F, f_last);
        step(1'b1, info, 1'b0);
        step(1'b1, len, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b0, 16'h0000, 1'b0);
        step(1'b0, 16'h0000, 1'b0);
        rst_n = 1'b1;
        phase = "R1";
        chk("R1 burst flag", {15'd0, burst_flag_o}, 16'd0);
        chk("R1 pk flag", {15'd0, pk_flag_o}, 16'd0);
        chk("R1 any flag", {15'd0, any_flag_o}, 16'd0);
        chk("R1 info", burst_info_o, 16'h0000);
        chk("R1 len", burst_len_o, 16'h0000);

        phase = "R7";
        step(1'b1, 16'h7FFE, 1'b0);
        step(1'b1, 16'h8001, 1'b0);
        step(1'b1, 16'h07F3, 1'b0);
        step(1'b1, 16'h2222, 1'b0);
        chk("R7 16-bit form ignored", {15'd0, pk_flag_o}, 16'd0);

        phase = "R6";
        step(1'b1, 16'h1FFF, 1'b1);
        step(1'b1, 16'h1FFF, 1'b0);
        step(1'b1, 16'hE800, 1'b0);
        step(1'b1, 16'h07F5, 1'b0);
        chk("R6 pk flag set", {15'd0, pk_flag_o}, 16'd1);
        chk("R9 any with pk", {15'd0, any_flag_o}, 16'd1);

        phase = "R8";
        idle_frames(4095);
        chk("R8 pk held at 4095 frames", {15'd0, pk_flag_o}, 16'd1);
        idle_frames(1);
        chk("R8 pk cleared at 4096", {15'd0, pk_flag_o}, 16'd0);
        chk("R9 any cleared", {15'd0, any_flag_o}, 16'd0);

        phase = "R2";
        burst_seq(16'h0015, 16'h1800, 1'b0);
        chk("R2 burst flag set", {15'd0, burst_flag_o}, 16'd1);
        chk("R4 info captured", burst_info_o, 16'h0015);
        chk("R4 len captured", burst_len_o, 16'h1800);
        chk("R8 pk independent", {15'd0, pk_flag_o}, 16'd0);
        idle_frames(3);

        phase = "R3";
        for (int i = 0; i < 7; i++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'hF872, 1'b0);
        step(1'b1, 16'h4E1F, 1'b0);
        step(1'b1, 16'h0001, 1'b0);
        step(1'b1, 16'h0100, 1'b0);
        chk("R3 long zero run info", burst_info_o, 16'h0001);
        for (int i = 0; i < 4; i++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'hF872, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'hF872, 1'b0);
        step(1'b1, 16'h4E1F, 1'b0);
        step(1'b1, 16'h0002, 1'b0);
        step(1'b1, 16'h0200, 1'b0);
        chk("R3 zero restarts match", burst_info_o, 16'h0002);
        for (int i = 0; i < 3; i++) step(1'b1, 16'h0000, 1'b0);
        step(1'b1, 16'hF872, 1'b0);
        step(1'b1, 16'h4E1F, 1'b0);
        step(1'b1, 16'h0003, 1'b0);
        chk("R3 short zero run rejected", burst_info_o, 16'h0002);

        phase = "R10";
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 16'h0000, 1'b0);
            step(1'b0, 16'hBEEF, 1'b0);
        end
        step(1'b1, 16'hF872, 1'b0);
        step(1'b0, 16'h1234, 1'b0);
        step(1'b1, 16'h4E1F, 1'b0);
        step(1'b0, 16'h5A5A, 1'b0);
        step(1'b1, 16'h0004, 1'b0);
        step(1'b0, 16'h6B6B, 1'b0);
        step(1'b1, 16'h0400, 1'b0);
        step(1'b0, 16'h7C7C, 1'b0);
        chk("R10 info ignores gaps", burst_info_o, 16'h0004);
        chk("R10 len ignores gaps", burst_len_o, 16'h0400);

        phase = "R5";
        idle_frames(4095);
        chk("R5 burst held at 4095 frames", {15'd0, burst_flag_o}, 16'd1);
        idle_frames(1);
        chk("R5 burst cleared at 4096", {15'd0, burst_flag_o}, 16'd0);

        phase = "R11";
        burst_seq(16'h0005, 16'h0500, 1'b0);
        idle_frames(4095);
        burst_seq(16'h0006, 16'h0600, 1'b1);
        chk("R11 coincident re-arm", {15'd0, burst_flag_o}, 16'd1);
        idle_frames(4095);
        chk("R11 strobe with hit not counted", {15'd0, burst_flag_o}, 16'd1);
        idle_frames(1);
        chk("R11 cleared after full count", {15'd0, burst_flag_o}, 16'd0);
        chk("R4 info held after timeout", burst_info_o, 16'h0006);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule